// File: doc/BRIEF.md
# Virtual Page-Length Scan Register

This block is a test-port data register that a scan host sees as a single scan chain as long as one program-memory page. Internally it holds only one byte of shift state. Bits arrive on the serial input, least significant bit first, while the register is selected and the shift phase is active. Every eighth bit completes a byte. That byte is written straight into an external page buffer through a simple byte-write port, and the buffer address then advances by one.

The host loads a whole page in one shift pass. The first bit is the least significant bit of the first instruction word and the last bit is the most significant bit of the last word. A separate command outside this block commits the buffer to memory. The test-port state machine, instruction decoding and the memory write itself are all outside this block. It takes decoded capture, shift and update phase strobes plus a select line, all clocked by the test clock.

The page size is a parameter: 64 words of 16 bits by default, which is 128 bytes. Buffer byte addresses follow shift order, so word `w` has its low byte at address `2w` and its high byte at address `2w+1`.

Top module: `vpage_load_reg`

## Requirements
- R1: After the asynchronous active-low reset, `tdo`, `bufWe` and `bufAddr` are all 0.
- R2: Bytes are assembled least significant bit first: the first bit shifted after a capture becomes bit 0 of the byte. `bufWe` goes high in the cycle after the clock edge that samples the eighth bit, with `bufData` holding that byte.
- R3: The k-th completed byte after a capture is written to address k. A 16-bit word shifted LSB first as word `w` lands as its low byte at `2w` and its high byte at `2w+1`.
- R4: `bufWe` is a single-cycle pulse, and there is exactly one pulse per eight shifted bits.
- R5: A capture strobe while selected resets the bit count and the byte address to 0, so the next completed byte goes to address 0.
- R6: After the last address of the page (127 by default), the next completed byte wraps to address 0 and overwrites it.
- R7: A partial byte of fewer than eight bits is never written to the buffer. After a capture it does not disturb the next full byte.
- R8: `tdo` is bit 0 of the internal shifter, so each shifted bit reappears on `tdo` eight shift cycles after it entered.
- R9: An update strobe has no effect: it produces no write and does not change the byte address used by later writes.
- R10: While `regSel` is low, shift and capture strobes are ignored: no write occurs and the byte address is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | This data register is the selected one |
| captureDr | input | 1 | Capture-phase strobe from the state machine |
| shiftDr | input | 1 | Shift-phase strobe from the state machine |
| updateDr | input | 1 | Update-phase strobe (has no effect) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the shifter |
| bufAddr | output | 7 | Page buffer byte address |
| bufData | output | 8 | Page buffer byte data |
| bufWe | output | 1 | Page buffer write strobe, one cycle |

## Verification
On every cycle, the assertions check several properties: the write strobe is a single-cycle pulse that always follows a selected shift edge; a selected capture zeroes the address; the address holds while the register is deselected; an update never causes a write; and `tdo` tracks the shifter's next bit. The following only the directed scenarios can show: byte values and bit order, the address sequence across a whole page, the wrap and overwrite, the cycle in which the strobe appears, discarding of a partial byte, and data reappearing on `tdo` after eight shifts.

// File: rtl/vpl_pkg.sv
package vpl_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W = $clog2(BYTE_BITS);

  typedef struct packed {
    logic clear;     // selected capture: restart count and address
    logic shiftEn;   // selected shift edge
    logic byteDone;  // this shift edge completes a byte
  } vpl_strobes_t;
endpackage

// File: rtl/vpl_ctrl.sv
module vpl_ctrl
  import vpl_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic              tck,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              captureDr,
  input  logic              shiftDr,
  output vpl_strobes_t      strobes,
  output logic [ADDR_W-1:0] byteAddr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_BITS - 1);

  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strobes.clear    = regSel && captureDr && !shiftDr;
    strobes.shiftEn  = regSel && shiftDr;
    strobes.byteDone = strobes.shiftEn && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteAddr <= '0;
    end else if (strobes.clear) begin
      bitCnt   <= '0;
      byteAddr <= '0;
    end else if (strobes.shiftEn) begin
      bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
      if (strobes.byteDone)
        byteAddr <= (byteAddr == LAST_ADDR) ? '0 : byteAddr + 1'b1;
    end
  end

  AST_CAPTURE_CLEARS: assert property (@(posedge tck) disable iff (!rstN)
    (regSel && captureDr && !shiftDr) |=> (byteAddr == '0)); // R5

  AST_DESELECT_HOLDS: assert property (@(posedge tck) disable iff (!rstN)
    !regSel |=> $stable(byteAddr)); // R10
endmodule

// File: rtl/vpl_datapath.sv
module vpl_datapath
  import vpl_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic                 tck,
  input  logic                 rstN,
  input  vpl_strobes_t         strobes,
  input  logic [ADDR_W-1:0]    byteAddr,
  input  logic                 tdi,
  output logic                 tdo,
  output logic [ADDR_W-1:0]    bufAddr,
  output logic [BYTE_BITS-1:0] bufData,
  output logic                 bufWe
);
  logic [BYTE_BITS-1:0] shiftReg;
  logic [BYTE_BITS-1:0] shiftNext;

  always_comb shiftNext = {tdi, shiftReg[BYTE_BITS-1:1]};

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bufWe    <= 1'b0;
      bufData  <= '0;
      bufAddr  <= '0;
    end else begin
      if (strobes.shiftEn) shiftReg <= shiftNext;
      bufWe <= strobes.byteDone;
      if (strobes.byteDone) begin
        bufData <= shiftNext;
        bufAddr <= byteAddr;
      end
    end
  end

  assign tdo = shiftReg[0];

  AST_WE_SINGLE_PULSE: assert property (@(posedge tck) disable iff (!rstN)
    bufWe |=> !bufWe); // R4

  AST_WE_AFTER_SHIFT: assert property (@(posedge tck) disable iff (!rstN)
    $rose(bufWe) |-> $past(strobes.shiftEn)); // R2

  AST_TDO_ADVANCES: assert property (@(posedge tck) disable iff (!rstN)
    strobes.shiftEn |=> (tdo == $past(shiftReg[1]))); // R8
endmodule

// File: rtl/vpage_load_reg.sv
module vpage_load_reg
  import vpl_pkg::*;
#(
  parameter int WORD_BITS  = 16,
  parameter int PAGE_WORDS = 64,
  localparam int PAGE_BYTES = PAGE_WORDS * WORD_BITS / BYTE_BITS,
  localparam int ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic                 tck,
  input  logic                 rstN,
  input  logic                 regSel,
  input  logic                 captureDr,
  input  logic                 shiftDr,
  input  logic                 updateDr,
  input  logic                 tdi,
  output logic                 tdo,
  output logic [ADDR_W-1:0]    bufAddr,
  output logic [BYTE_BITS-1:0] bufData,
  output logic                 bufWe
);
  vpl_strobes_t      strobes;
  logic [ADDR_W-1:0] byteAddr;

  vpl_ctrl #(.PAGE_BYTES(PAGE_BYTES)) i_ctrl (
    .tck(tck), .rstN(rstN), .regSel(regSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .strobes(strobes), .byteAddr(byteAddr)
  );

  vpl_datapath #(.PAGE_BYTES(PAGE_BYTES)) i_datapath (
    .tck(tck), .rstN(rstN), .strobes(strobes), .byteAddr(byteAddr),
    .tdi(tdi), .tdo(tdo), .bufAddr(bufAddr), .bufData(bufData), .bufWe(bufWe)
  );

  AST_UPDATE_NO_WRITE: assert property (@(posedge tck) disable iff (!rstN)
    (updateDr && !shiftDr) |=> !bufWe); // R9
endmodule

// File: tb/test_vpage_load_reg.sv
module test_vpage_load_reg;
  localparam int NBYTES = 128;

  logic tck = 1'b0, rstN = 1'b0;
  logic regSel = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo, bufWe;
  logic [6:0] bufAddr;
  logic [7:0] bufData;

  int testCnt = 0, failCnt = 0;
  logic [6:0] logAddr [0:511];
  logic [7:0] logData [0:511];
  int logCnt = 0;
  bit prevWe = 1'b0, doublePulse = 1'b0;

  always #10 tck = ~tck;

  vpage_load_reg i_vpage_load_reg (
    .tck(tck), .rstN(rstN), .regSel(regSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .bufAddr(bufAddr), .bufData(bufData), .bufWe(bufWe)
  );

  // write-port monitor, samples just after each rising edge
  always @(posedge tck) begin
    #1;
    if (bufWe) begin
      if (logCnt < 512) begin
        logAddr[logCnt] = bufAddr;
        logData[logCnt] = bufData;
      end
      logCnt++;
      if (prevWe) doublePulse = 1'b1;
    end
    prevWe = bufWe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge tck); endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 37 + seed * 11 + 3) & 255);
  endfunction

  task automatic capture();
    captureDr = 1'b1; step(); captureDr = 1'b0;
  endtask

  task automatic shiftBit(input logic b);
    tdi = b; shiftDr = 1'b1; step(); shiftDr = 1'b0;
  endtask

  task automatic shiftByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) shiftBit(b[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic testReset();
    check(tdo == 1'b0 && bufWe == 1'b0 && bufAddr == 7'd0, "R1 reset outputs",
          {tdo, bufWe, bufAddr}, 0);
  endtask

  task automatic testByteTiming();
    int base;
    logic [7:0] b = 8'b1000_0001;
    regSel = 1'b1; capture();
    base = logCnt;
    for (int i = 0; i < 7; i++) shiftBit(b[i]);
    check(logCnt == base, "R2 no write before eighth bit", logCnt - base, 0);
    shiftBit(b[7]);
    check(logCnt == base + 1, "R2 write in cycle after eighth edge", logCnt - base, 1);
    check(logData[base] == b, "R2 LSB-first byte value", logData[base], b);
    idle(2);
  endtask

  task automatic testFullPage();
    int base, errs = 0;
    logic [15:0] w;
    capture();
    base = logCnt;
    for (int k = 0; k < NBYTES / 2; k++) begin
      w = {pat(2 * k + 1, 1), pat(2 * k, 1)};
      for (int i = 0; i < 16; i++) shiftBit(w[i]);
    end
    idle(2);
    check(logCnt - base == NBYTES, "R4 one write per byte", logCnt - base, NBYTES);
    for (int k = 0; k < NBYTES; k++)
      if (logAddr[base + k] != 7'(k) || logData[base + k] != pat(k, 1)) errs++;
    check(errs == 0, "R3 word bytes at 2w and 2w+1", errs, 0);
    check(!doublePulse, "R4 strobe single cycle", int'(doublePulse), 0);
  endtask

  task automatic testCaptureClear();
    int base;
    capture();
    shiftByte(8'h11); shiftByte(8'h22); shiftByte(8'h33);
    shiftBit(1'b1); shiftBit(1'b0);
    capture();
    base = logCnt;
    shiftByte(8'h5A);
    idle(1);
    check(logCnt - base == 1 && logAddr[base] == 7'd0, "R5 capture restarts address",
          logAddr[base], 0);
    check(logData[base] == 8'h5A, "R5 capture restarts bit count", logData[base], 8'h5A);
  endtask

  task automatic testWrap();
    int base;
    capture();
    base = logCnt;
    for (int k = 0; k < NBYTES + 2; k++) shiftByte(pat(k, 4));
    idle(1);
    check(logCnt - base == NBYTES + 2, "R6 write count with wrap", logCnt - base, NBYTES + 2);
    check(logAddr[base + NBYTES - 1] == 7'd127, "R6 last address", logAddr[base + NBYTES - 1], 127);
    check(logAddr[base + NBYTES] == 7'd0 && logAddr[base + NBYTES + 1] == 7'd1,
          "R6 wrap to zero", logAddr[base + NBYTES], 0);
  endtask

  task automatic testPartial();
    int base;
    capture();
    base = logCnt;
    for (int i = 0; i < 5; i++) shiftBit(1'b1);
    idle(4);
    check(logCnt == base, "R7 partial byte not written", logCnt - base, 0);
    capture();
    shiftByte(8'hC4);
    idle(1);
    check(logCnt - base == 1 && logData[base] == 8'hC4 && logAddr[base] == 7'd0,
          "R7 next byte clean", logData[base], 8'hC4);
  endtask

  task automatic testTdo();
    int errs = 0;
    logic [7:0] a = 8'b0110_1011, b = 8'b1001_0100;
    capture();
    shiftByte(a);
    for (int i = 0; i < 8; i++) begin
      if (tdo !== a[i]) errs++;
      shiftBit(b[i]);
    end
    check(errs == 0, "R8 tdo replays bits after eight shifts", errs, 0);
    idle(1);
  endtask

  task automatic testUpdate();
    int base;
    capture();
    base = logCnt;
    shiftByte(8'h81);
    idle(1);
    updateDr = 1'b1; step(); updateDr = 1'b0;
    idle(2);
    check(logCnt - base == 1, "R9 update makes no write", logCnt - base, 1);
    shiftByte(8'h7E);
    idle(1);
    check(logAddr[base + 1] == 7'd1, "R9 update keeps address", logAddr[base + 1], 1);
  endtask

  task automatic testDeselect();
    int base;
    capture();
    base = logCnt;
    shiftByte(8'h01);
    regSel = 1'b0;
    shiftByte(8'hFF);
    capture();
    idle(2);
    check(logCnt - base == 1, "R10 deselected shift writes nothing", logCnt - base, 1);
    regSel = 1'b1;
    shiftByte(8'h02);
    idle(1);
    check(logAddr[base + 1] == 7'd1 && logData[base + 1] == 8'h02,
          "R10 deselected capture ignored", logAddr[base + 1], 1);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    failCnt++; testCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    idle(2);
    testReset();
    rstN = 1'b1;
    idle(1);
    testByteTiming();
    testFullPage();
    testCaptureClear();
    testWrap();
    testPartial();
    testTdo();
    testUpdate();
    testDeselect();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule